// File: doc/BRIEF.md
# Interrupt Vector Arbitration Unit

This unit sits between a 16-bit processor's instruction sequencer and the sources that can divert its control flow. At every instruction-end strobe it weighs the software interrupts raised by that instruction (exceptions, explicit INT vectors, single-step) against the hardware sources (a non-maskable line and a maskable request). It picks one winner, emits its 8-bit type together with the vector-table byte address, and tells the sequencer which return address to push.

Hardware requests are examined only at the instruction-end strobe, and a software interrupt from the same instruction always wins. A maskable request can take its vector from an internal controller in the same decision. It can also run a request/accept/valid handshake with the bus and wait for the vector there. During that handshake, further instruction-end strobes are ignored. The take pulse is the sequencer's cue to start the push and table fetch, and both of those lie outside this unit.

Top module: `irq_vec_arb`

## Requirements
- R1: `tbl_addr_o` always equals `type_o` multiplied by four, i.e. `{type_o, 2'b00}`.
- R2: An exception request (`exc_req_i`) present at a boundary beats every other source. `take_o` is high in the cycle after the boundary edge, with `type_o = exc_type_i` (a divide error is signalled with type 0).
- R3: An INT-instruction request with no exception is taken with `type_o = swi_type_i`, for any of the 256 values. It beats single-step, NMI and the maskable request.
- R4: With `trap_flag_i` set and `instr_class_i` = 0 (plain instruction), single-step is taken as type 1. Class 1 (prefix), 2 (segment-register write) and 3 (WAIT) suppress it.
- R5: When single-step and a pending NMI meet at one boundary, single-step is taken. The NMI stays pending and is taken at the next boundary.
- R6: A rising edge on `nmi_i` sets a pending bit, whatever the value of `ie_i`. The NMI is taken as type 2, and being taken clears the pending bit, so a level held high is taken only once.
- R7: The maskable request `intr_i` has no effect while `ie_i` is low.
- R8: With `ie_i` high and `ack_ext_i` low, the maskable request is taken at the boundary with `type_o = ctl_vec_i`.
- R9: With `ie_i` high and `ack_ext_i` high, no take occurs at the boundary. `inta_req_o` goes high in the following cycle and stays high until `inta_ack_i`. The unit then waits for `inta_vld_i`, and `take_o` is high for exactly the next cycle with `type_o = inta_vec_i`. Boundaries seen during the handshake are ignored.
- R10: `ret_sel_o` is 1 (the ESC instruction) for an exception with `esc_trap_i` and no prefix, and 2 (the override prefix) when `esc_prefix_i` is also set. It is 0 (the next instruction) for every other take.
- R11: `take_o` is never high except in the cycle after a boundary edge or after an accepted vector-valid strobe.
- R12: During and straight after reset, `take_o`, `inta_req_o`, `type_o` and `ret_sel_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction-end strobe |
| exc_req_i | input | 1 | Exception raised by the ending instruction |
| exc_type_i | input | 8 | Internally supplied exception type |
| esc_trap_i | input | 1 | Exception is an ESC trap with trapping enabled |
| esc_prefix_i | input | 1 | Segment-override prefix precedes the ESC instruction |
| swi_req_i | input | 1 | INT instruction ended |
| swi_type_i | input | 8 | Vector carried by the INT instruction |
| trap_flag_i | input | 1 | Single-step flag |
| instr_class_i | input | 2 | 0 plain, 1 prefix, 2 segment write, 3 WAIT |
| nmi_i | input | 1 | Non-maskable interrupt line, edge sensitive |
| intr_i | input | 1 | Maskable interrupt request |
| ie_i | input | 1 | Interrupt-enable flag |
| ack_ext_i | input | 1 | Maskable vector comes over the bus handshake |
| ctl_vec_i | input | 8 | Vector from the internal interrupt controller |
| inta_req_o | output | 1 | Acknowledge request to the bus |
| inta_ack_i | input | 1 | Bus has accepted the acknowledge request |
| inta_vld_i | input | 1 | Bus vector is valid |
| inta_vec_i | input | 8 | Vector returned by the bus |
| take_o | output | 1 | One-cycle take-interrupt pulse |
| type_o | output | 8 | Type of the last taken interrupt |
| tbl_addr_o | output | 10 | Vector-table byte address |
| ret_sel_o | output | 2 | Return address: 0 next, 1 ESC, 2 prefix |

## Verification
The bench builds the unit with the default 8-bit type width, so the whole type space is reachable, including type 255 at table address 1020. That width lets the directed cases hit the ends of the range and the fixed types 0, 1 and 2. The random phase stacks every source on one boundary, varies the instruction class and toggles the NMI line between boundaries. As a result the precedence chain and the single clearing of the NMI pending bit are exercised in many combinations. The external handshake is driven with stalls between request, accept and valid, and a competing boundary is placed inside the wait.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {RET_NEXT = 2'd0, RET_ESC = 2'd1, RET_PFX = 2'd2} ret_sel_e;
  typedef enum logic [1:0] {CLS_PLAIN = 2'd0, CLS_PREFIX = 2'd1, CLS_SEGWR = 2'd2, CLS_WAIT = 2'd3} iclass_e;
  typedef enum logic [2:0] {SRC_NONE, SRC_EXC, SRC_SWI, SRC_STEP, SRC_NMI, SRC_MASK} src_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_ACK} ack_st_e;
  localparam int unsigned TYPE_STEP = 1;
  localparam int unsigned TYPE_NMI  = 2;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic clr_i,
  output logic pend_o
);
  logic nmi_q, pend_q;
  logic rise;

  assign rise = nmi_i & ~nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q <= nmi_i;
      // a fresh edge outranks a same-cycle clear
      if (rise)       pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_vec_pkg::*;
#(
  parameter int unsigned TYPE_W = 8
) (
  input  logic              exc_req_i,
  input  logic [TYPE_W-1:0] exc_type_i,
  input  logic              esc_trap_i,
  input  logic              esc_prefix_i,
  input  logic              swi_req_i,
  input  logic [TYPE_W-1:0] swi_type_i,
  input  logic              trap_flag_i,
  input  iclass_e           iclass_i,
  input  logic              nmi_pend_i,
  input  logic              intr_i,
  input  logic              ie_i,
  output src_e              src_o,
  output logic [TYPE_W-1:0] type_o,
  output ret_sel_e          ret_o
);
  logic step_ok;

  assign step_ok = trap_flag_i & (iclass_i == CLS_PLAIN);

  always_comb begin
    src_o  = SRC_NONE;
    type_o = '0;
    ret_o  = RET_NEXT;
    if (exc_req_i) begin
      src_o  = SRC_EXC;
      type_o = exc_type_i;
      if (esc_trap_i) ret_o = esc_prefix_i ? RET_PFX : RET_ESC;
    end else if (swi_req_i) begin
      src_o  = SRC_SWI;
      type_o = swi_type_i;
    end else if (step_ok) begin
      src_o  = SRC_STEP;
      type_o = TYPE_W'(TYPE_STEP);
    end else if (nmi_pend_i) begin
      src_o  = SRC_NMI;
      type_o = TYPE_W'(TYPE_NMI);
    end else if (intr_i && ie_i) begin
      src_o  = SRC_MASK;
    end
  end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_vec_pkg::*;
#(
  parameter int unsigned TYPE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ack_i,
  input  logic              vld_i,
  input  logic [TYPE_W-1:0] vec_i,
  output logic              busy_o,
  output logic              req_o,
  output logic              done_o,
  output logic [TYPE_W-1:0] vec_o
);
  ack_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_REQ;
      ST_REQ:  if (ack_i)   st_d = ST_ACK;
      ST_ACK:  if (vld_i)   st_d = ST_IDLE;
      default:              st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign busy_o = (st_q != ST_IDLE);
  assign req_o  = (st_q == ST_REQ);
  assign done_o = (st_q == ST_ACK) & vld_i;
  assign vec_o  = vec_i;
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
  import irq_vec_pkg::*;
#(
  parameter int unsigned TYPE_W = 8,
  localparam int unsigned ADDR_W = TYPE_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic              exc_req_i,
  input  logic [TYPE_W-1:0] exc_type_i,
  input  logic              esc_trap_i,
  input  logic              esc_prefix_i,
  input  logic              swi_req_i,
  input  logic [TYPE_W-1:0] swi_type_i,
  input  logic              trap_flag_i,
  input  logic [1:0]        instr_class_i,
  input  logic              nmi_i,
  input  logic              intr_i,
  input  logic              ie_i,
  input  logic              ack_ext_i,
  input  logic [TYPE_W-1:0] ctl_vec_i,
  output logic              inta_req_o,
  input  logic              inta_ack_i,
  input  logic              inta_vld_i,
  input  logic [TYPE_W-1:0] inta_vec_i,
  output logic              take_o,
  output logic [TYPE_W-1:0] type_o,
  output logic [ADDR_W-1:0] tbl_addr_o,
  output logic [1:0]        ret_sel_o
);
  logic              nmi_pend, nmi_clr;
  src_e              src;
  logic [TYPE_W-1:0] sel_type;
  ret_sel_e          sel_ret;
  logic              busy, fsm_done, fire, ext_start;
  logic [TYPE_W-1:0] fsm_vec;

  logic              take_q;
  logic [TYPE_W-1:0] type_q;
  ret_sel_e          ret_q;

  irq_nmi_latch u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_i),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pend)
  );

  irq_prio_sel #(.TYPE_W(TYPE_W)) u_sel (
    .exc_req_i    (exc_req_i),
    .exc_type_i   (exc_type_i),
    .esc_trap_i   (esc_trap_i),
    .esc_prefix_i (esc_prefix_i),
    .swi_req_i    (swi_req_i),
    .swi_type_i   (swi_type_i),
    .trap_flag_i  (trap_flag_i),
    .iclass_i     (iclass_e'(instr_class_i)),
    .nmi_pend_i   (nmi_pend),
    .intr_i       (intr_i),
    .ie_i         (ie_i),
    .src_o        (src),
    .type_o       (sel_type),
    .ret_o        (sel_ret)
  );

  irq_ack_fsm #(.TYPE_W(TYPE_W)) u_ack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ext_start),
    .ack_i   (inta_ack_i),
    .vld_i   (inta_vld_i),
    .vec_i   (inta_vec_i),
    .busy_o  (busy),
    .req_o   (inta_req_o),
    .done_o  (fsm_done),
    .vec_o   (fsm_vec)
  );

  // boundaries are dropped while a bus acknowledge is outstanding
  assign fire      = boundary_i & ~busy & (src != SRC_NONE);
  assign ext_start = fire & (src == SRC_MASK) & ack_ext_i;
  assign nmi_clr   = fire & (src == SRC_NMI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      type_q <= '0;
      ret_q  <= RET_NEXT;
    end else begin
      take_q <= 1'b0;
      if (fsm_done) begin
        take_q <= 1'b1;
        type_q <= fsm_vec;
        ret_q  <= RET_NEXT;
      end else if (fire && !ext_start) begin
        take_q <= 1'b1;
        type_q <= (src == SRC_MASK) ? ctl_vec_i : sel_type;
        ret_q  <= sel_ret;
      end
    end
  end

  assign take_o     = take_q;
  assign type_o     = type_q;
  assign tbl_addr_o = {type_q, 2'b00};
  assign ret_sel_o  = ret_q;
endmodule

// File: rtl/irq_vec_arb_chk.sv
module irq_vec_arb_chk #(
  parameter int unsigned TYPE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              boundary_i,
  input logic              exc_req_i,
  input logic              esc_trap_i,
  input logic              inta_vld_i,
  input logic              inta_req_o,
  input logic              take_o,
  input logic [TYPE_W-1:0] type_o,
  input logic [TYPE_W+1:0] tbl_addr_o,
  input logic [1:0]        ret_sel_o
);
  AST_TBL_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_addr_o == {type_o, 2'b00}); // R1

  AST_TAKE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ($past(boundary_i) || $past(inta_vld_i))); // R11

  AST_NO_TAKE_IN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_req_o |-> !take_o); // R9

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inta_req_o) |-> !$past(take_o) && $past(boundary_i)); // R9

  AST_RET_ESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && ret_sel_o != 2'd0) |-> $past(exc_req_i && esc_trap_i)); // R10

  AST_RET_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_sel_o != 2'd3); // R10
endmodule

bind irq_vec_arb irq_vec_arb_chk #(.TYPE_W(TYPE_W)) u_chk (.*);

// File: tb/irq_vec_arb_bench.sv
module irq_vec_arb_bench;
  localparam int TW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic boundary = 0, exc_req = 0, esc_trap = 0, esc_pfx = 0, swi_req = 0;
  logic trap = 0, nmi = 0, intr = 0, ie = 0, ack_ext = 0, inta_ack = 0, inta_vld = 0;
  logic [TW-1:0] exc_type = 0, swi_type = 0, ctl_vec = 0, inta_vec = 0;
  logic [1:0] iclass = 0;
  logic inta_req, take;
  logic [TW-1:0] vtype;
  logic [TW+1:0] tbl_addr;
  logic [1:0] ret_sel;

  int n_chk = 0, n_bad = 0;
  bit nmi_pend_m = 0, nmi_prev_m = 0;

  always #5 clk = ~clk;

  irq_vec_arb u_irq_vec_arb (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary),
    .exc_req_i(exc_req), .exc_type_i(exc_type), .esc_trap_i(esc_trap), .esc_prefix_i(esc_pfx),
    .swi_req_i(swi_req), .swi_type_i(swi_type), .trap_flag_i(trap), .instr_class_i(iclass),
    .nmi_i(nmi), .intr_i(intr), .ie_i(ie), .ack_ext_i(ack_ext), .ctl_vec_i(ctl_vec),
    .inta_req_o(inta_req), .inta_ack_i(inta_ack), .inta_vld_i(inta_vld), .inta_vec_i(inta_vec),
    .take_o(take), .type_o(vtype), .tbl_addr_o(tbl_addr), .ret_sel_o(ret_sel)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(10 * 150000);
    n_bad++;
    $display("FAIL watchdog: run hung, act=running exp=finished");
    summary();
    $finish;
  end

  task automatic chk(string req, bit e_take, logic [TW-1:0] e_type, logic [1:0] e_ret);
    n_chk++;
    if (take !== e_take ||
        (e_take && (vtype !== e_type || tbl_addr !== {e_type, 2'b00} || ret_sel !== e_ret))) begin
      n_bad++;
      $display("FAIL %s: act take=%0b type=%0d addr=%0d ret=%0d exp take=%0b type=%0d addr=%0d ret=%0d",
               req, take, vtype, tbl_addr, ret_sel, e_take, e_type, {e_type, 2'b00}, e_ret);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0b exp=%0b", req, act, exp);
    end
  endtask

  // one boundary strobe; returns at the negedge where the result is visible
  task automatic bnd();
    @(negedge clk) boundary = 1;
    @(negedge clk) boundary = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_in();
    exc_req = 0; esc_trap = 0; esc_pfx = 0; swi_req = 0; trap = 0; iclass = 0;
    intr = 0; ie = 0; ack_ext = 0;
  endtask

  // expected outcome of one boundary (internal-vector path only)
  function automatic void model(input bit pend, output bit e_take,
                                output logic [TW-1:0] e_type, output logic [1:0] e_ret,
                                output bit nmi_taken);
    e_take = 1; e_ret = 0; e_type = 0; nmi_taken = 0;
    if (exc_req) begin
      e_type = exc_type;
      if (esc_trap) e_ret = esc_pfx ? 2'd2 : 2'd1;
    end else if (swi_req)                  e_type = swi_type;
    else if (trap && iclass == 2'd0)       e_type = 8'd1;
    else if (pend) begin e_type = 8'd2; nmi_taken = 1; end
    else if (intr && ie)                   e_type = ctl_vec;
    else e_take = 0;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R12 reset take", 0, 0, 0);
    chk_bit("R12 reset inta_req", inta_req, 1'b0);
    chk_bit("R12 reset type", vtype == 0 && ret_sel == 0, 1'b1);
    idle(2);
    rst_n = 1;
    idle(1);
    chk("R12 after reset", 0, 0, 0);

    // R2: divide error beats everything
    exc_req = 1; exc_type = 0; swi_req = 1; swi_type = 8'h21; trap = 1; intr = 1; ie = 1;
    bnd(); chk("R2 divide error type 0", 1, 8'd0, 2'd0);
    idle(1); chk("R11 pulse ends", 0, 0, 0);

    // R10: ESC trap return selection
    clr_in(); exc_req = 1; exc_type = 8'd7; esc_trap = 1;
    bnd(); chk("R10 esc return", 1, 8'd7, 2'd1);
    esc_pfx = 1;
    bnd(); chk("R10 prefix return", 1, 8'd7, 2'd2);

    // R3/R1: INT 255
    clr_in(); swi_req = 1; swi_type = 8'hFF; trap = 1; intr = 1; ie = 1; ctl_vec = 8'h40;
    bnd(); chk("R3 R1 int 255", 1, 8'hFF, 2'd0);

    // R4: single-step and its suppression
    clr_in(); trap = 1;
    bnd(); chk("R4 step plain", 1, 8'd1, 2'd0);
    for (int c = 1; c < 4; c++) begin
      iclass = 2'(c); bnd(); chk("R4 step suppressed", 0, 0, 0);
    end

    // R5/R6: step before NMI, NMI once, ie irrelevant
    clr_in(); nmi = 1; idle(1);
    trap = 1;
    bnd(); chk("R5 step before nmi", 1, 8'd1, 2'd0);
    trap = 0;
    bnd(); chk("R5 R6 nmi next boundary", 1, 8'd2, 2'd0);
    bnd(); chk("R6 nmi level not retaken", 0, 0, 0);
    nmi = 0; idle(1);

    // R7/R8: maskable
    clr_in(); intr = 1; ie = 0; ctl_vec = 8'h40;
    bnd(); chk("R7 masked", 0, 0, 0);
    ie = 1;
    bnd(); chk("R8 internal vector", 1, 8'h40, 2'd0);

    // R9: external handshake
    ack_ext = 1;
    bnd(); chk("R9 no take at boundary", 0, 0, 0);
    chk_bit("R9 inta_req raised", inta_req, 1'b1);
    clr_in(); idle(2);
    chk_bit("R9 inta_req held", inta_req, 1'b1);
    exc_req = 1; exc_type = 8'd5;
    bnd(); chk("R9 boundary ignored in req", 0, 0, 0);
    exc_req = 0;
    inta_ack = 1; @(negedge clk) inta_ack = 0;
    chk_bit("R9 inta_req dropped", inta_req, 1'b0);
    idle(1); chk("R9 waiting for valid", 0, 0, 0);
    exc_req = 1;
    bnd(); chk("R9 boundary ignored in ack", 0, 0, 0);
    exc_req = 0;
    inta_vec = 8'h83; inta_vld = 1;
    @(negedge clk) inta_vld = 0;
    chk("R9 bus vector taken", 1, 8'h83, 2'd0);
    idle(1); chk("R9 single pulse", 0, 0, 0);

    // R11: no boundary, no take
    exc_req = 1; swi_req = 1; trap = 1; intr = 1; ie = 1;
    idle(3); chk("R11 no boundary", 0, 0, 0);
    clr_in(); idle(1);

    // random phase
    nmi_pend_m = 0; nmi_prev_m = 0;
    for (int it = 0; it < 600; it++) begin
      bit e_take, taken;
      logic [TW-1:0] e_type;
      logic [1:0] e_ret;
      boundary = 0;
      nmi = ($urandom % 4) == 0;
      exc_req = ($urandom % 5) == 0; swi_req = ($urandom % 4) == 0;
      trap = $urandom % 2; intr = $urandom % 2; ie = $urandom % 2;
      @(negedge clk);
      chk("R11 random idle", 0, 0, 0);
      if (nmi && !nmi_prev_m) nmi_pend_m = 1;
      nmi_prev_m = nmi;
      exc_req = ($urandom % 6) == 0; exc_type = 8'($urandom % 32);
      esc_trap = $urandom % 2; esc_pfx = $urandom % 2;
      swi_req = ($urandom % 5) == 0; swi_type = 8'($urandom);
      trap = ($urandom % 3) == 0; iclass = 2'($urandom);
      intr = $urandom % 2; ie = $urandom % 2; ctl_vec = 8'($urandom);
      model(nmi_pend_m, e_take, e_type, e_ret, taken);
      bnd();
      chk("R2 R3 R4 R5 R6 R7 R8 R10 random", e_take, e_type, e_ret);
      if (taken) nmi_pend_m = 0;
    end

    clr_in(); nmi = 0;
    summary();
    $finish;
  end
endmodule